// File: doc/BRIEF.md
# Stream-Headed Quadword DMA Receiver

This block empties a 32-bit word FIFO that an inbound link fills and stores the contents to memory as 128-bit quadwords. The stream itself says where the data goes. Whenever the pending quadword count reaches zero, the block takes a four-word header from the FIFO. The header supplies a new count, a destination address and a new upper half for the control register. The block then moves that many quadwords, four words at a time, raising the address by 16 after each one.

A channel is armed by setting the enable bit in the control register. It keeps running, header by header, until a header's interrupt request or end marker tells it to stop. At that point it clears the enable bit and gives a single-cycle interrupt. When stall control is on, some headers also publish the address just past their payload, so that a consumer can tell how far the data has been written.

Top module: `dchain_rx`

## Requirements
- R1: After reset `ctrl_o`, `stall_addr_o`, `irq_o`, `mem_we_o` and `fifo_pop_o` are all zero.
- R2: While control bit 8 (enable) is clear, the block pops no FIFO word and issues no memory write, whatever the FIFO holds.
- R3: With a zero count and no stop condition pending, the block pops four words as a header. Bits 15:0 of the first word become the quadword count and the second word becomes the destination address. The third and fourth words are discarded.
- R4: A header replaces control bits 31:16 with bits 31:16 of its first word and leaves bits 15:0 unchanged.
- R5: Each quadword is built from four consecutive FIFO words, the first popped word in bits 31:0 and the fourth in bits 127:96. It is written in one cycle at the current address, and the address then rises by 16. Exactly as many quadwords are written as the header count says.
- R6: A quadword or header is started only when at least 4 words are buffered. With fewer, the block waits and pops nothing.
- R7: When the count is zero, the stop conditions are checked first. If a header has been received and control bit 31 is set, the block stops even if a further header is waiting in the FIFO.
- R8: Bit 30 of a header's first word sets a sticky end flag. Once that header's count runs out, the block stops.
- R9: With a zero count, no stop condition and fewer than 4 buffered words, the block waits with the enable bit still set and raises no interrupt.
- R10: Stopping clears control bit 8 and raises `irq_o` for exactly one cycle. It also clears the header-received and end flags.
- R11: If `stall_en_i` is high and bits 29:28 of a header's first word are 0, `stall_addr_o` becomes header address + count × 16. Any other header leaves `stall_addr_o` unchanged.
- R12: A header with a zero count writes nothing. Without flags, the block goes straight on to the next header. With bit 31 set, it stops at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| ctrl_wdata_i | input | 32 | Value written to the control register |
| ctrl_o | output | 32 | Control register (bit 8 enable, bits 31:16 from the last header) |
| stall_en_i | input | 1 | Enables stall-address updates |
| fifo_rdata_i | input | 32 | Word at the head of the FIFO (show-ahead) |
| fifo_count_i | input | CNT_W | Number of words held in the FIFO |
| fifo_pop_o | output | 1 | Consumes the head word at the next clock edge |
| mem_we_o | output | 1 | Quadword write strobe |
| mem_addr_o | output | 32 | Quadword byte address |
| mem_wdata_o | output | 128 | Quadword data |
| stall_addr_o | output | 32 | End address of the last qualifying payload |
| irq_o | output | 1 | One-cycle pulse when the channel stops |

## Verification
The bench targets the order of the zero-count checks. A design that reads the next header before testing the interrupt bit would leave fewer words in the FIFO and write data that should never be written. A header whose count is zero is another trap: handling it wrongly either writes a phantom quadword or stalls the chain. Arrival is trickled in, with a header split across three and one words and data held back at three words. This exposes a design that starts a quadword early and pops past the data, or one that stops when it should wait. The bench also checks word order inside each quadword, that the control register's lower half survives header loads, that non-qualifying headers leave the stall address alone, and that the interrupt pulse lasts one cycle.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int WORD_W   = 32;
  localparam int QW_WORDS = 4;
  localparam int QW_W     = WORD_W * QW_WORDS;
  localparam int IDX_W    = $clog2(QW_WORDS);
  localparam int QWC_W    = 16;
  localparam int ENA_BIT  = 8;
  localparam int IRQ_BIT  = 31;

  typedef enum logic [1:0] {PH_EVAL, PH_HDR, PH_DATA} phase_e;

  typedef struct packed {
    logic             irq;
    logic             fin;
    logic [1:0]       kind;
    logic [11:0]      misc;
    logic [QWC_W-1:0] qwc;
  } hdr_w0_t;
endpackage

// File: rtl/dchain_word_pack.sv
module dchain_word_pack
  import dchain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [QW_W-1:0]   qw_o
);
  // last lane is the live head word; earlier lanes are held
  for (genvar g = 0; g < QW_WORDS - 1; g++) begin : g_lane
    logic [WORD_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q <= '0;
      else if (take_i && idx_i == IDX_W'(g))     lane_q <= word_i;
    end
    assign qw_o[g*WORD_W +: WORD_W] = lane_q;
  end
  assign qw_o[(QW_WORDS-1)*WORD_W +: WORD_W] = word_i;
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
  import dchain_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [WORD_W-1:0] ctrl_wdata_i,
  input  logic              stall_en_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic [QW_W-1:0]   qw_i,
  output logic              fifo_pop_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [QW_W-1:0]   mem_wdata_o,
  output logic [WORD_W-1:0] stall_addr_o,
  output logic              irq_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(QW_WORDS - 1);

  phase_e            ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [QWC_W-1:0]  qwc_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] ctrl_q;
  logic              chain_q, fin_q;

  logic    enabled, room, stop_req, start_hdr, start_dat, last_word;
  hdr_w0_t hdr0;
  logic [WORD_W-1:0] hdr_addr;

  always_comb begin
    enabled   = ctrl_q[ENA_BIT];
    room      = fifo_count_i >= CNT_W'(QW_WORDS);
    stop_req  = (ph_q == PH_EVAL) && enabled && (qwc_q == '0) &&
                ((chain_q && ctrl_q[IRQ_BIT]) || fin_q);
    start_hdr = (ph_q == PH_EVAL) && enabled && (qwc_q == '0) && !stop_req && room;
    start_dat = (ph_q == PH_EVAL) && enabled && (qwc_q != '0) && room;
    last_word = (ph_q != PH_EVAL) && (idx_q == LAST_IDX);
    hdr0      = hdr_w0_t'(qw_i[WORD_W-1:0]);
    hdr_addr  = qw_i[2*WORD_W-1:WORD_W];
  end

  assign fifo_pop_o = (ph_q != PH_EVAL);
  assign idx_o      = idx_q;
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q         <= PH_EVAL;
      idx_q        <= '0;
      qwc_q        <= '0;
      addr_q       <= '0;
      ctrl_q       <= '0;
      chain_q      <= 1'b0;
      fin_q        <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      stall_addr_o <= '0;
      irq_o        <= 1'b0;
    end else begin
      irq_o    <= stop_req;
      mem_we_o <= last_word && (ph_q == PH_DATA);

      if (ctrl_wr_i)                               ctrl_q <= ctrl_wdata_i;
      else if (stop_req)                           ctrl_q[ENA_BIT] <= 1'b0;
      else if (last_word && ph_q == PH_HDR)        ctrl_q[WORD_W-1:WORD_W/2] <= qw_i[WORD_W-1:WORD_W/2];

      if (stop_req) begin
        chain_q <= 1'b0;
        fin_q   <= 1'b0;
      end

      unique case (ph_q)
        PH_EVAL: begin
          idx_q <= '0;
          if (start_hdr)      ph_q <= PH_HDR;
          else if (start_dat) ph_q <= PH_DATA;
        end
        default: begin
          idx_q <= idx_q + IDX_W'(1);
          if (last_word) begin
            ph_q <= PH_EVAL;
            if (ph_q == PH_HDR) begin
              qwc_q   <= hdr0.qwc;
              addr_q  <= hdr_addr;
              chain_q <= 1'b1;
              fin_q   <= fin_q | hdr0.fin;
              if (stall_en_i && hdr0.kind == 2'b00)
                stall_addr_o <= hdr_addr + {{(WORD_W-QWC_W-4){1'b0}}, hdr0.qwc, 4'b0000};
            end else begin
              mem_wdata_o <= qw_i;
              mem_addr_o  <= addr_q;
              addr_q      <= addr_q + WORD_W'(16);
              qwc_q       <= qwc_q - QWC_W'(1);
            end
          end
        end
      endcase
    end
  end

  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R10
  irq_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(ctrl_wr_i) |-> !ctrl_o[ENA_BIT]);
  // R6
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> fifo_count_i != '0);
  // R5
  we_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !fifo_pop_o);
  // R7
  stop_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_EVAL && enabled && qwc_q == '0 && chain_q && ctrl_q[IRQ_BIT] && !ctrl_wr_i)
    |=> irq_o && !fifo_pop_o);
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[ENA_BIT] && ph_q == PH_EVAL) |=> !fifo_pop_o);
endmodule

// File: rtl/dchain_rx.sv
module dchain_rx
  import dchain_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_o,
  input  logic              stall_en_i,
  input  logic [31:0]       fifo_rdata_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  output logic              fifo_pop_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [127:0]      mem_wdata_o,
  output logic [31:0]       stall_addr_o,
  output logic              irq_o
);
  logic [IDX_W-1:0] idx;
  logic [QW_W-1:0]  qw;

  dchain_word_pack u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (fifo_pop_o),
    .idx_i  (idx),
    .word_i (fifo_rdata_i),
    .qw_o   (qw)
  );

  dchain_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .stall_en_i   (stall_en_i),
    .fifo_count_i (fifo_count_i),
    .qw_i         (qw),
    .fifo_pop_o   (fifo_pop_o),
    .idx_o        (idx),
    .ctrl_o       (ctrl_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .stall_addr_o (stall_addr_o),
    .irq_o        (irq_o)
  );
endmodule

// File: tb/dchain_rx_test.sv
module dchain_rx_test;
  localparam int CNT_W = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         ctrl_wr;
  logic [31:0]  ctrl_wdata;
  logic [31:0]  ctrl;
  logic         stall_en;
  logic [31:0]  fifo_rdata;
  logic [CNT_W-1:0] fifo_count;
  logic         fifo_pop;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [31:0]  stall_addr;
  logic         irq;

  dchain_rx #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_o(ctrl), .stall_en_i(stall_en), .fifo_rdata_i(fifo_rdata),
    .fifo_count_i(fifo_count), .fifo_pop_o(fifo_pop), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .stall_addr_o(stall_addr),
    .irq_o(irq)
  );

  // bench FIFO, show-ahead
  logic [31:0] fmem [256];
  logic [CNT_W-1:0] wp, rp;
  logic        push_v;
  logic [31:0] push_d;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0;
    end else begin
      if (push_v) begin fmem[wp[7:0]] <= push_d; wp <= wp + 1'b1; end
      if (fifo_pop) rp <= rp + 1'b1;
    end
  end
  assign fifo_count = wp - rp;
  assign fifo_rdata = fmem[rp[7:0]];

  int checks = 0, failures = 0;
  int irq_cnt = 0, wr_cnt = 0;
  logic irq_prev = 1'b0;
  logic [31:0]  ex_addr [$];
  logic [127:0] ex_data [$];
  logic [31:0]  stream  [$];
  logic [31:0]  last_w0, exp_stall;
  logic [15:0]  low;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        wr_cnt++;
        if (ex_addr.size() == 0) chk(0, "R5", "unexpected write", mem_addr, 0);
        else begin
          chk(mem_addr == ex_addr[0], "R5", "write address", mem_addr, ex_addr[0]);
          chk(mem_wdata == ex_data[0], "R5", "quadword data", mem_wdata, ex_data[0]);
          void'(ex_addr.pop_front());
          void'(ex_data.pop_front());
        end
      end
      if (irq) begin
        irq_cnt++;
        if (irq_prev) chk(0, "R10", "irq longer than one cycle", 1, 0);
      end
      irq_prev = irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] mk_w0(bit ir, bit fn, int kind, int qwc);
    logic [11:0] misc;
    misc = 12'(($urandom % 4096));
    return {ir, fn, 2'(kind), misc, 16'(qwc)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; push_v = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0; stall_en = 1'b0;
    ex_addr.delete(); ex_data.delete(); stream.delete();
    exp_stall = '0; last_w0 = '0; low = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_cnt = 0; wr_cnt = 0; irq_prev = 1'b0;
    @(negedge clk);
  endtask

  task automatic add_block(bit ir, bit fn, int kind, int qwc, logic [31:0] a);
    logic [31:0] w0, d0, d1, d2, d3;
    w0 = mk_w0(ir, fn, kind, qwc);
    stream.push_back(w0); stream.push_back(a);
    stream.push_back($urandom); stream.push_back($urandom);
    last_w0 = w0;
    if (stall_en && kind == 0) exp_stall = a + 32'(qwc) * 16;
    for (int q = 0; q < qwc; q++) begin
      d0 = $urandom; d1 = $urandom; d2 = $urandom; d3 = $urandom;
      stream.push_back(d0); stream.push_back(d1); stream.push_back(d2); stream.push_back(d3);
      ex_addr.push_back(a + 32'(q) * 16);
      ex_data.push_back({d3, d2, d1, d0});
    end
  endtask

  task automatic feed(int n, int gap_pct);
    int k;
    k = (n < 0 || n > stream.size()) ? stream.size() : n;
    for (int i = 0; i < k; i++) begin
      while (($urandom % 100) < gap_pct) begin @(negedge clk); push_v = 1'b0; end
      @(negedge clk); push_v = 1'b1; push_d = stream.pop_front();
    end
    @(negedge clk); push_v = 1'b0;
  endtask

  task automatic start(logic [15:0] lo);
    low = lo | 16'h0100;
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = {16'h0000, low};
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wait_irq();
    int t;
    t = 0;
    while (irq_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_chk(string tag, int left);
    chk(ex_addr.size() == 0, "R5", {tag, " missing writes"}, ex_addr.size(), 0);
    chk(irq_cnt == 1, "R10", {tag, " irq count"}, irq_cnt, 1);
    chk(ctrl == {last_w0[31:16], low & 16'hFEFF}, "R4", {tag, " control after stop"},
        ctrl, {last_w0[31:16], low & 16'hFEFF});
    chk(stall_addr == exp_stall, "R11", {tag, " stall address"}, stall_addr, exp_stall);
    chk(32'(fifo_count) == 32'(left), "R7", {tag, " words left"}, fifo_count, left);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // R1
    chk(ctrl == 0 && stall_addr == 0, "R1", "ctrl/stall after reset", {ctrl, stall_addr}, 0);
    chk(!irq && !mem_we && !fifo_pop, "R1", "strobes after reset", {irq, mem_we, fifo_pop}, 0);

    // R2: disabled channel ignores data
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 32'h0000_00FF;
    @(negedge clk); ctrl_wr = 1'b0;
    for (int i = 0; i < 8; i++) stream.push_back($urandom);
    feed(-1, 0);
    repeat (20) @(negedge clk);
    chk(fifo_count == 8, "R2", "fifo untouched while disabled", fifo_count, 8);
    chk(wr_cnt == 0 && irq_cnt == 0, "R2", "no write or irq while disabled", {wr_cnt, irq_cnt}, 0);

    // R9 / R6: trickled header and data
    do_reset();
    start(16'h00A5);
    add_block(0, 1, 1, 2, 32'h0000_1000);
    feed(3, 0);
    repeat (20) @(negedge clk);
    chk(fifo_count == 3, "R9", "partial header not popped", fifo_count, 3);
    chk(ctrl[8] == 1'b1 && irq_cnt == 0, "R9", "still enabled, no irq", {ctrl[8], irq_cnt}, 1);
    feed(4, 0);
    repeat (20) @(negedge clk);
    chk(fifo_count == 3, "R6", "partial quadword not popped", fifo_count, 3);
    chk(wr_cnt == 0, "R6", "no write before full quadword", wr_cnt, 0);
    chk(ctrl[31:16] == last_w0[31:16], "R3", "header consumed and loaded", ctrl[31:16], last_w0[31:16]);
    feed(-1, 0);
    wait_irq();
    finish_chk("trickle R8", 0);

    // R7: irq header stops before a waiting header
    do_reset();
    start(16'h3C00);
    add_block(1, 0, 3, 1, 32'h0000_4000);
    stream.push_back(32'h0000_0001); stream.push_back(32'h0000_8000);
    stream.push_back(0); stream.push_back(0);
    for (int i = 0; i < 4; i++) stream.push_back($urandom);
    feed(-1, 0);
    wait_irq();
    finish_chk("irq-first R7", 8);
    chk(wr_cnt == 1, "R7", "only one quadword written", wr_cnt, 1);

    // R12: zero-count headers
    do_reset();
    start(16'h0001);
    add_block(0, 0, 2, 0, 32'h0000_9000);
    add_block(0, 1, 1, 1, 32'h0000_A000);
    feed(-1, 0);
    wait_irq();
    finish_chk("zero-count skip R12", 0);
    chk(wr_cnt == 1, "R12", "zero count writes nothing", wr_cnt, 1);
    do_reset();
    start(16'h0002);
    add_block(1, 0, 1, 0, 32'h0000_B000);
    feed(-1, 0);
    wait_irq();
    finish_chk("zero-count irq R12", 0);
    chk(wr_cnt == 0, "R12", "immediate stop writes nothing", wr_cnt, 0);

    // R11: stall address update and hold
    do_reset();
    stall_en = 1'b1;
    start(16'h0000);
    add_block(0, 0, 0, 3, 32'h0000_2000);
    add_block(0, 1, 2, 1, 32'h0000_3000);
    feed(-1, 0);
    wait_irq();
    finish_chk("stall R11", 0);
    chk(stall_addr == 32'h0000_2030, "R11", "stall held by non-zero kind", stall_addr, 32'h2030);

    // random chains: R3 R4 R5 R8 R11
    for (int s = 0; s < 12; s++) begin
      int nh;
      bit use_irq;
      do_reset();
      stall_en = 1'($urandom % 2);
      start(16'($urandom));
      nh = 1 + ($urandom % 3);
      use_irq = 1'($urandom % 2);
      for (int h = 0; h < nh; h++) begin
        if (h == nh - 1) add_block(use_irq, !use_irq, $urandom % 4, $urandom % 5, $urandom);
        else             add_block(0, 0, $urandom % 4, $urandom % 5, $urandom);
      end
      feed(-1, 30);
      wait_irq();
      finish_chk(use_irq ? "random irq R3" : "random end R8", 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule